// File: doc/BRIEF.md
# Indirect Register Access Window

This block is a small I/O-space slave that reaches a large internal register file through only two 32-bit locations. Software first writes a target index into the index location, then reads or writes the data location; the data access is turned into a request on an internal register bus at the latched index. The I/O region is 32 bytes and takes only full, aligned 32-bit accesses.

Before anything is forwarded, the latched index is checked against three boundaries. Only indices in the low range reach the register bus. Indices in the undefined, flash and unknown ranges are refused quietly: reads return zero, writes are dropped, and a 2-bit class output pulses for one cycle to show which range was hit. The index register has no reset, so its value survives a reset until software overwrites it.

Top module: `iwin_top`

## Requirements
- R1: A full-word write to the index location (offset 0x00) stores all 32 bits; a read of that location returns the stored value unchanged.
- R2: When the latched index is below 0x1FFFF, a data-location (offset 0x04) access issues one register-bus request with address equal to the index bits [16:0]; a write passes the host data unchanged, and a read returns the register-bus read data.
- R3: An index of exactly 0x1FFFF is not forwarded and is classed as undefined.
- R4: A register-bus request holds its address, data and direction stable until ready is seen; a forwarded read completes only after read-valid is returned.
- R5: On a non-forwarded data access the class output shows 1 for indices in [0x1FFFF, 0x7FFFF), 2 for [0x7FFFF, 0xFFFFF) and 3 for 0xFFFFF and above, for exactly the one cycle in which done is high; otherwise it shows 0.
- R6: A non-forwarded data read returns zero and a non-forwarded data write issues no register-bus request.
- R7: Accesses to offsets 0x08 to 0x1C read zero, issue no register-bus request and leave the latched index unchanged.
- R8: An access whose byte enable is not 4'hF or whose address bits [1:0] are not zero reads zero and has no effect on the index or the register bus.
- R9: Asserting reset does not change the latched index.
- R10: Every accepted access is answered by a done pulse of exactly one cycle; ready is low from acceptance until after done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_req_i | input | 1 | Host access request |
| host_we_i | input | 1 | Host access is a write |
| host_addr_i | input | 5 | Byte offset in the I/O region |
| host_be_i | input | 4 | Byte enables, must be 4'hF |
| host_wdata_i | input | 32 | Host write data |
| host_rdy_o | output | 1 | Block can accept an access |
| host_done_o | output | 1 | Access completion pulse |
| host_rdata_o | output | 32 | Read data, valid with done |
| cls_o | output | 2 | Range class of a refused data access |
| rb_req_o | output | 1 | Register-bus request valid |
| rb_we_o | output | 1 | Register-bus write |
| rb_addr_o | output | 17 | Register-bus index |
| rb_wdata_o | output | 32 | Register-bus write data |
| rb_gnt_i | input | 1 | Register-bus ready |
| rb_rvalid_i | input | 1 | Register-bus read data valid |
| rb_rdata_i | input | 32 | Register-bus read data |

## Verification
Indices are driven on both sides of each range boundary (0x1FFFE/0x1FFFF, 0x7FFFE/0x7FFFF, 0xFFFFE/0xFFFFF) and at the all-ones value, which separates an off-by-one compare from a correct one and shows a wrong class code. Random indices biased toward the forwarded range, mixed with random register-bus ready and read-valid delays, tell apart a design that ignores the handshake from one that waits, and a shadow of the register contents shows whether a refused write leaked through. Partial byte enables, misaligned offsets and the spare offsets show whether decoding is too loose, and a reset between index write and read shows whether the index is wrongly cleared.

// File: rtl/iwin_pkg.sv
package iwin_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned IOA_W   = 5;
  localparam int unsigned RB_AW   = 17;

  localparam logic [DW-1:0] FWD_LIMIT   = 32'h0001_FFFF;
  localparam logic [DW-1:0] UNDEF_LIMIT = 32'h0007_FFFF;
  localparam logic [DW-1:0] FLASH_LIMIT = 32'h000F_FFFF;

  localparam logic [2:0] OFS_INDEX = 3'd0;
  localparam logic [2:0] OFS_DATA  = 3'd1;

  typedef enum logic [1:0] {
    CLS_NONE    = 2'd0,
    CLS_UNDEF   = 2'd1,
    CLS_FLASH   = 2'd2,
    CLS_UNKNOWN = 2'd3
  } rng_cls_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_RESP = 2'd3
  } seq_st_e;
endpackage

// File: rtl/iwin_idx_latch.sv
module iwin_idx_latch #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  // Deliberately unreset: index survives reset until overwritten.
  logic [DW-1:0] idx_q;

  always_ff @(posedge clk_i) begin
    if (we_i) idx_q <= d_i;
  end

  assign q_o = idx_q;
endmodule

// File: rtl/iwin_range_cls.sv
module iwin_range_cls
  import iwin_pkg::*;
#(
  parameter int unsigned    W       = 32,
  parameter logic [W-1:0]   LIM_FWD = W'(FWD_LIMIT),
  parameter logic [W-1:0]   LIM_UND = W'(UNDEF_LIMIT),
  parameter logic [W-1:0]   LIM_FLS = W'(FLASH_LIMIT)
) (
  input  logic [W-1:0] idx_i,
  output logic         fwd_o,
  output rng_cls_e     cls_o
);
  always_comb begin
    fwd_o = 1'b0;
    if (idx_i < LIM_FWD) begin
      fwd_o = 1'b1;
      cls_o = CLS_NONE;
    end else if (idx_i < LIM_UND) begin
      cls_o = CLS_UNDEF;
    end else if (idx_i < LIM_FLS) begin
      cls_o = CLS_FLASH;
    end else begin
      cls_o = CLS_UNKNOWN;
    end
  end
endmodule

// File: rtl/iwin_rb_seq.sv
module iwin_rb_seq
  import iwin_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 17
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fwd_start_i,
  input  logic          local_start_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] local_rdata_i,
  input  rng_cls_e      local_cls_i,
  output logic          idle_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output rng_cls_e      cls_o,
  output logic          rb_req_o,
  output logic          rb_we_o,
  output logic [AW-1:0] rb_addr_o,
  output logic [DW-1:0] rb_wdata_o,
  input  logic          rb_gnt_i,
  input  logic          rb_rvalid_i,
  input  logic [DW-1:0] rb_rdata_i
);
  seq_st_e       st_q;
  logic [DW-1:0] rdata_q;
  rng_cls_e      cls_q;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      rdata_q <= '0;
      cls_q   <= CLS_NONE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (fwd_start_i) begin
            we_q    <= we_i;
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
            rdata_q <= '0;
            st_q    <= ST_REQ;
          end else if (local_start_i) begin
            rdata_q <= local_rdata_i;
            cls_q   <= local_cls_i;
            st_q    <= ST_RESP;
          end
        end
        ST_REQ: begin
          if (rb_gnt_i) st_q <= we_q ? ST_RESP : ST_WAIT;
        end
        ST_WAIT: begin
          if (rb_rvalid_i) begin
            rdata_q <= rb_rdata_i;
            st_q    <= ST_RESP;
          end
        end
        ST_RESP: begin
          cls_q <= CLS_NONE;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o     = (st_q == ST_IDLE);
  assign done_o     = (st_q == ST_RESP);
  assign rdata_o    = rdata_q;
  assign cls_o      = cls_q;
  assign rb_req_o   = (st_q == ST_REQ);
  assign rb_we_o    = we_q;
  assign rb_addr_o  = addr_q;
  assign rb_wdata_o = wdata_q;
endmodule

// File: rtl/iwin_top.sv
module iwin_top
  import iwin_pkg::*;
#(
  parameter int unsigned DATA_W = DW,
  parameter int unsigned ADDR_W = IOA_W,
  parameter int unsigned RBA_W  = RB_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [3:0]        host_be_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic              host_rdy_o,
  output logic              host_done_o,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic [1:0]        cls_o,
  output logic              rb_req_o,
  output logic              rb_we_o,
  output logic [RBA_W-1:0]  rb_addr_o,
  output logic [DATA_W-1:0] rb_wdata_o,
  input  logic              rb_gnt_i,
  input  logic              rb_rvalid_i,
  input  logic [DATA_W-1:0] rb_rdata_i
);
  localparam int unsigned OFS_W = ADDR_W - 2;

  logic              acc;
  logic              legal;
  logic [OFS_W-1:0]  ofs;
  logic              hit_idx, hit_data;
  logic              idx_we;
  logic [DATA_W-1:0] idx;
  logic              fwd;
  rng_cls_e          cls_chk;
  logic              fwd_start, local_start;
  logic [DATA_W-1:0] local_rdata;
  rng_cls_e          local_cls;
  rng_cls_e          cls_seq;
  logic              idle;

  assign acc      = host_req_i && idle;
  assign legal    = (host_be_i == 4'hF) && (host_addr_i[1:0] == 2'b00);
  assign ofs      = host_addr_i[ADDR_W-1:2];
  assign hit_idx  = legal && (ofs == OFS_W'(OFS_INDEX));
  assign hit_data = legal && (ofs == OFS_W'(OFS_DATA));
  assign idx_we   = acc && host_we_i && hit_idx;

  iwin_idx_latch #(.DW(DATA_W)) u_latch (
    .clk_i (clk_i),
    .we_i  (idx_we),
    .d_i   (host_wdata_i),
    .q_o   (idx)
  );

  iwin_range_cls #(.W(DATA_W)) u_cls (
    .idx_i (idx),
    .fwd_o (fwd),
    .cls_o (cls_chk)
  );

  assign fwd_start   = acc && hit_data && fwd;
  assign local_start = acc && !fwd_start;
  assign local_rdata = (hit_idx && !host_we_i) ? idx : '0;
  assign local_cls   = hit_data ? cls_chk : CLS_NONE;

  iwin_rb_seq #(.DW(DATA_W), .AW(RBA_W)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fwd_start_i   (fwd_start),
    .local_start_i (local_start),
    .we_i          (host_we_i),
    .addr_i        (idx[RBA_W-1:0]),
    .wdata_i       (host_wdata_i),
    .local_rdata_i (local_rdata),
    .local_cls_i   (local_cls),
    .idle_o        (idle),
    .done_o        (host_done_o),
    .rdata_o       (host_rdata_o),
    .cls_o         (cls_seq),
    .rb_req_o      (rb_req_o),
    .rb_we_o       (rb_we_o),
    .rb_addr_o     (rb_addr_o),
    .rb_wdata_o    (rb_wdata_o),
    .rb_gnt_i      (rb_gnt_i),
    .rb_rvalid_i   (rb_rvalid_i),
    .rb_rdata_i    (rb_rdata_i)
  );

  assign host_rdy_o = idle;
  assign cls_o      = cls_seq;
endmodule

// File: rtl/iwin_chk.sv
module iwin_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RBA_W  = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_rdy_o,
  input logic              host_done_o,
  input logic [1:0]        cls_o,
  input logic              rb_req_o,
  input logic              rb_we_o,
  input logic [RBA_W-1:0]  rb_addr_o,
  input logic [DATA_W-1:0] rb_wdata_o,
  input logic              rb_gnt_i
);
  // R4: request stays up with stable payload until ready
  a_r4_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb_req_o && !rb_gnt_i) |=> (rb_req_o && $stable(rb_addr_o) && $stable(rb_we_o)
                                 && $stable(rb_wdata_o)));
  // R5: class pulse lasts one cycle and coincides with done
  a_r5_cls_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_o != 2'd0) |=> (cls_o == 2'd0));
  a_r5_cls_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_o != 2'd0) |-> host_done_o);
  // R6: refused access never drives the register bus
  a_r6_no_req_on_cls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_o != 2'd0) |-> !rb_req_o);
  // R10: done is a single-cycle pulse, ready low while busy
  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_done_o |=> !host_done_o);
  a_r10_rdy_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rb_req_o || host_done_o) |-> !host_rdy_o);
endmodule

bind iwin_top iwin_chk #(.DATA_W(DATA_W), .RBA_W(RBA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_rdy_o  (host_rdy_o),
  .host_done_o (host_done_o),
  .cls_o       (cls_o),
  .rb_req_o    (rb_req_o),
  .rb_we_o     (rb_we_o),
  .rb_addr_o   (rb_addr_o),
  .rb_wdata_o  (rb_wdata_o),
  .rb_gnt_i    (rb_gnt_i)
);

// File: tb/iwin_top_tb_top.sv
`timescale 1ns/1ps
module iwin_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [4:0]  host_addr = '0;
  logic [3:0]  host_be = 4'hF;
  logic [31:0] host_wdata = '0;
  logic        host_rdy, host_done;
  logic [31:0] host_rdata;
  logic [1:0]  cls;
  logic        rb_req, rb_we;
  logic [16:0] rb_addr;
  logic [31:0] rb_wdata;
  logic        rb_gnt = 1'b0, rb_rvalid = 1'b0;
  logic [31:0] rb_rdata = '0;

  int total = 0, bad = 0;
  int hs_cnt = 0;
  logic [16:0] last_addr;
  logic [31:0] last_wdata;
  logic [31:0] mem [64];
  logic [31:0] shadow [64];
  logic [31:0] cur_idx;

  always #4 clk = ~clk;

  iwin_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .host_req_i(host_req), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_be_i(host_be), .host_wdata_i(host_wdata),
    .host_rdy_o(host_rdy), .host_done_o(host_done), .host_rdata_o(host_rdata),
    .cls_o(cls),
    .rb_req_o(rb_req), .rb_we_o(rb_we), .rb_addr_o(rb_addr), .rb_wdata_o(rb_wdata),
    .rb_gnt_i(rb_gnt), .rb_rvalid_i(rb_rvalid), .rb_rdata_i(rb_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_fwd(input logic [31:0] i);
    return i < 32'h1FFFF;
  endfunction

  function automatic logic [1:0] exp_cls(input logic [31:0] i);
    if (i < 32'h1FFFF) return 2'd0;
    if (i < 32'h7FFFF) return 2'd1;
    if (i < 32'hFFFFF) return 2'd2;
    return 2'd3;
  endfunction

  // register-file stand-in with random ready and read latency
  initial begin
    bit rd_pend = 1'b0;
    int rd_dly = 0;
    logic [5:0] rd_a = '0;
    for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 ^ (i * 32'h0101_0101);
    forever begin
      @(negedge clk);
      rb_rvalid = 1'b0;
      if (rd_pend) begin
        if (rd_dly == 0) begin
          rb_rvalid = 1'b1;
          rb_rdata  = mem[rd_a];
          rd_pend   = 1'b0;
        end else rd_dly--;
      end
      rb_gnt = ($urandom % 2) == 0;
      if (rb_req && rb_gnt && rst_n) begin
        hs_cnt++;
        last_addr = rb_addr;
        if (rb_we) begin
          mem[rb_addr[5:0]] = rb_wdata;
          last_wdata = rb_wdata;
        end else begin
          rd_pend = 1'b1;
          rd_dly  = $urandom % 3;
          rd_a    = rb_addr[5:0];
        end
      end
    end
  end

  task automatic host_io(input bit we, input logic [4:0] a, input logic [3:0] be,
                         input logic [31:0] wd, output logic [31:0] rd,
                         output logic [1:0] c, output int hs);
    int h0 = hs_cnt;
    int guard = 0;
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_be = be; host_wdata = wd;
    while (!host_rdy && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    host_req = 1'b0;
    while (!host_done && guard < 100) begin @(negedge clk); guard++; end
    if (guard >= 100) check(1'b0, "R10 timeout", 32'(guard), 32'd0);
    rd = host_rdata; c = cls;
    @(negedge clk);
    check(!host_done && host_rdy && cls == 2'd0, "R10 done pulse", {30'd0, host_done, host_rdy}, 32'h1);
    hs = hs_cnt - h0;
  endtask

  task automatic set_idx(input logic [31:0] v);
    logic [31:0] rd; logic [1:0] c; int hs;
    host_io(1'b1, 5'h00, 4'hF, v, rd, c, hs);
    cur_idx = v;
  endtask

  task automatic data_access(input bit we, input logic [31:0] wd, input string tag);
    logic [31:0] rd; logic [1:0] c; int hs;
    logic [31:0] exp_rd;
    host_io(we, 5'h04, 4'hF, wd, rd, c, hs);
    check(c == exp_cls(cur_idx), {tag, " R5 class"}, {30'd0, c}, {30'd0, exp_cls(cur_idx)});
    if (exp_fwd(cur_idx)) begin
      check(hs == 1, {tag, " R2 one request"}, 32'(hs), 32'd1);
      check(last_addr == cur_idx[16:0], {tag, " R2 bus address"}, {15'd0, last_addr}, cur_idx);
      if (we) begin
        check(last_wdata == wd, {tag, " R2 bus wdata"}, last_wdata, wd);
        shadow[cur_idx[5:0]] = wd;
      end else begin
        exp_rd = shadow[cur_idx[5:0]];
        check(rd == exp_rd, {tag, " R4 read data"}, rd, exp_rd);
      end
    end else begin
      check(hs == 0, {tag, " R6 no request"}, 32'(hs), 32'd0);
      if (!we) check(rd == 32'd0, {tag, " R6 read zero"}, rd, 32'd0);
    end
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd; logic [1:0] c; int hs;
    void'($urandom(32'd1234));
    for (int i = 0; i < 64; i++) shadow[i] = 32'hA500_0000 ^ (i * 32'h0101_0101);
    repeat (3) @(negedge clk);
    check(host_rdy && !host_done && !rb_req && cls == 2'd0, "R10 reset state",
          {28'd0, host_rdy, host_done, rb_req, |cls}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 index write/readback
    set_idx(32'hDEAD_BEEF);
    host_io(1'b0, 5'h00, 4'hF, 32'd0, rd, c, hs);
    check(rd == 32'hDEAD_BEEF, "R1 index readback", rd, 32'hDEAD_BEEF);

    // R2 forwarded write then read
    set_idx(32'd5);
    data_access(1'b1, 32'h1234_5678, "dir");
    data_access(1'b0, 32'd0, "dir");
    set_idx(32'h0001_FFFE);
    data_access(1'b1, 32'hCAFE_0001, "edge");
    data_access(1'b0, 32'd0, "edge");

    // R3 exact boundary
    set_idx(32'h0001_FFFF);
    data_access(1'b0, 32'd0, "R3");
    data_access(1'b1, 32'h5555_AAAA, "R3");
    check(shadow[6'h3F] == mem[6'h3F], "R3 R6 write dropped", mem[6'h3F], shadow[6'h3F]);

    // R5 range edges
    set_idx(32'h0007_FFFE); data_access(1'b0, 32'd0, "R5 und top");
    set_idx(32'h0007_FFFF); data_access(1'b0, 32'd0, "R5 fls low");
    set_idx(32'h000F_FFFE); data_access(1'b1, 32'h1, "R5 fls top");
    set_idx(32'h000F_FFFF); data_access(1'b0, 32'd0, "R5 unk low");
    set_idx(32'hFFFF_FFFF); data_access(1'b1, 32'h2, "R5 unk top");

    // R7 spare offsets
    set_idx(32'd9);
    for (int o = 2; o < 8; o++) begin
      host_io(1'b1, 5'(o * 4), 4'hF, 32'hFFFF_0000, rd, c, hs);
      check(hs == 0 && c == 2'd0, "R7 spare write", 32'(hs), 32'd0);
      host_io(1'b0, 5'(o * 4), 4'hF, 32'd0, rd, c, hs);
      check(rd == 32'd0 && hs == 0, "R7 spare read", rd, 32'd0);
    end
    host_io(1'b0, 5'h00, 4'hF, 32'd0, rd, c, hs);
    check(rd == 32'd9, "R7 index kept", rd, 32'd9);

    // R8 partial and misaligned
    host_io(1'b1, 5'h00, 4'h3, 32'h0000_0077, rd, c, hs);
    host_io(1'b1, 5'h01, 4'hF, 32'h0000_0088, rd, c, hs);
    host_io(1'b1, 5'h04, 4'h1, 32'h0000_0099, rd, c, hs);
    check(hs == 0, "R8 partial data write", 32'(hs), 32'd0);
    host_io(1'b0, 5'h00, 4'hC, 32'd0, rd, c, hs);
    check(rd == 32'd0, "R8 partial read zero", rd, 32'd0);
    host_io(1'b0, 5'h00, 4'hF, 32'd0, rd, c, hs);
    check(rd == 32'd9, "R8 index unchanged", rd, 32'd9);

    // R9 reset keeps index
    set_idx(32'h0BAD_F00D);
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    host_io(1'b0, 5'h00, 4'hF, 32'd0, rd, c, hs);
    check(rd == 32'h0BAD_F00D, "R9 index after reset", rd, 32'h0BAD_F00D);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int sel = $urandom % 8;
      logic [31:0] v;
      case ($urandom % 4)
        0, 1: v = $urandom % 32'h1FFFF;
        2:    v = 32'h1FFF0 + ($urandom % 32);
        default: v = $urandom;
      endcase
      if (sel < 2) set_idx(v);
      else if (sel < 5) data_access(1'b1, $urandom, "rnd");
      else if (sel < 7) data_access(1'b0, 32'd0, "rnd");
      else begin
        host_io(1'b0, 5'h00, 4'hF, 32'd0, rd, c, hs);
        check(rd == cur_idx, "R1 rnd index", rd, cur_idx);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule